// File: doc/BRIEF.md
# Vector Register Index Remapper

This unit translates a linear element count into physical register numbers for a vector issue loop. Software describes a block of registers as a shape of one, two or three dimensions with sizes X, Y and Z, starting at a base register. It also chooses which dimension moves fastest. After a start pulse the unit walks every element of the shape once. For each element it offers the register number `base + x + y*X + z*X*Y`, wrapped to the 7-bit register file. The data never moves. Only the register numbers seen by the vector engine are reordered.

With the X dimension fastest, the walk is plain contiguous access: base, base+1, and so on. With Y fastest on a 4-wide by 3-high block, the engine sees the block in transposed order. This is the order a matrix multiply needs for its second operand, and it costs no move instructions.

The output is a valid/ready stream. `idx_valid` stays high for the whole walk. An element counts as consumed only on a clock edge where both `idx_valid` and `idx_ready` are high. While `idx_ready` is low, the offered element and its `idx_last` flag are held unchanged. The vector engine can therefore stall the walk for any number of cycles and lose nothing.

Top module: `vreg_remap`

## Requirements
- R1: After reset, `idx_valid` and `idx_last` are low and stay low until a start pulse.
- R2: A start pulse latches the configuration. In the cycle after start, `idx_valid` is high and `idx` equals the latched base.
- R3: With order code 0 (X fastest, then Y, then Z), the walk yields base, base+1, base+2, and so on, in order.
- R4: For X=4, Y=3 at base 0 with order code 2 (Y fastest, then X, then Z), the walk yields 0,4,8,1,5,9,2,6,10,3,7,11.
- R5: The order code gives the dimensions from fastest to slowest: 0=XYZ, 1=XZY, 2=YXZ, 3=YZX, 4=ZXY, 5=ZYX. Codes 6 and 7 act as code 0. Every element's index is base + x + y*X + z*X*Y.
- R6: While `idx_valid` is high and `idx_ready` is low, `idx`, `idx_last` and `idx_valid` hold their values.
- R7: Exactly X*Y*Z elements are offered. `idx_last` is high only with the final one. After the final element is accepted, `idx_valid` is low from the next cycle.
- R8: Index arithmetic wraps modulo 128. For example, base 120 with 16 elements in order 0 yields 120..127 and then 0..7.
- R9: A start during a walk abandons it. The next cycle offers element zero of the newly latched configuration.
- R10: Each size field holds size minus one in 4 bits, so sizes run from 1 to 16. An all-zero shape yields one element, with `idx_last` high.
- R11: Configuration inputs have no effect except in the cycle where start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and begin a walk |
| cfg_base | input | 7 | First register of the block |
| cfg_xs | input | 4 | X size minus one |
| cfg_ys | input | 4 | Y size minus one |
| cfg_zs | input | 4 | Z size minus one |
| cfg_order | input | 3 | Dimension order code |
| idx_ready | input | 1 | Consumer accepts the offered index |
| idx_valid | output | 1 | An index is offered |
| idx | output | 7 | Physical register number |
| idx_last | output | 1 | Offered index is the final element |

## Verification
The first index is due one edge after the edge that samples start. Each later index is due one edge after an edge where valid and ready were both high. Valid falls one edge after the final element is accepted. The bench changes inputs on the falling edge and samples outputs on the following falling edge. It keeps its own element counter and advances it only after a rising edge where it held ready high. Each check therefore compares against the element that the handshake history makes due, including during stall patterns and mid-walk restarts.

// File: rtl/vremap_pkg.sv
package vremap_pkg;
  parameter int IDX_W  = 7;  // register number width
  parameter int DIM_W  = 4;  // size-minus-one field width
  parameter int ORD_W  = 3;  // order code width
  parameter int N_DIM  = 3;  // number of dimensions
  localparam int LVL_W = 2;  // width of a dimension level / dimension id

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic [DIM_W-1:0] xs;
    logic [DIM_W-1:0] ys;
    logic [DIM_W-1:0] zs;
    logic [ORD_W-1:0] order;
  } vr_cfg_t;

  // Speed level of a dimension (0 = fastest) for a given order code.
  // Dimension ids: 0 = X, 1 = Y, 2 = Z.
  function automatic logic [LVL_W-1:0] dim_level(input logic [ORD_W-1:0] ord,
                                                  input int dim);
    logic [LVL_W-1:0] lx, ly, lz;
    case (ord)
      3'd1:    begin lx = 2'd0; lz = 2'd1; ly = 2'd2; end
      3'd2:    begin ly = 2'd0; lx = 2'd1; lz = 2'd2; end
      3'd3:    begin ly = 2'd0; lz = 2'd1; lx = 2'd2; end
      3'd4:    begin lz = 2'd0; lx = 2'd1; ly = 2'd2; end
      3'd5:    begin lz = 2'd0; ly = 2'd1; lx = 2'd2; end
      default: begin lx = 2'd0; ly = 2'd1; lz = 2'd2; end
    endcase
    case (dim)
      0:       return lx;
      1:       return ly;
      default: return lz;
    endcase
  endfunction
endpackage

// File: rtl/vremap_digit.sv
module vremap_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val,
  output logic         at_max
);
  assign at_max = (val == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (clr) begin
      val <= '0;
    end else if (inc) begin
      val <= at_max ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/vremap_walk.sv
module vremap_walk
  import vremap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [DIM_W-1:0] xs,
  input  logic [DIM_W-1:0] ys,
  input  logic [DIM_W-1:0] zs,
  input  logic [ORD_W-1:0] order,
  output logic [DIM_W-1:0] cx,
  output logic [DIM_W-1:0] cy,
  output logic [DIM_W-1:0] cz,
  output logic             final_elem
);
  logic [DIM_W-1:0] lim    [N_DIM];
  logic [DIM_W-1:0] coord  [N_DIM];
  logic             at_max [N_DIM];
  logic             inc    [N_DIM];
  logic [LVL_W-1:0] lvl    [N_DIM];

  assign lim[0] = xs;
  assign lim[1] = ys;
  assign lim[2] = zs;

  // A dimension steps when every faster dimension is at its limit.
  always_comb begin
    for (int d = 0; d < N_DIM; d++) begin
      lvl[d] = dim_level(order, d);
    end
    for (int d = 0; d < N_DIM; d++) begin
      inc[d] = adv;
      for (int e = 0; e < N_DIM; e++) begin
        if (e != d && lvl[e] < lvl[d]) begin
          inc[d] = inc[d] & at_max[e];
        end
      end
    end
  end

  for (genvar g = 0; g < N_DIM; g++) begin : g_dim
    vremap_digit #(.W(DIM_W)) u_digit (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .inc    (inc[g]),
      .lim    (lim[g]),
      .val    (coord[g]),
      .at_max (at_max[g])
    );
  end

  assign cx = coord[0];
  assign cy = coord[1];
  assign cz = coord[2];
  assign final_elem = at_max[0] & at_max[1] & at_max[2];
endmodule

// File: rtl/vremap_addr.sv
module vremap_addr
  import vremap_pkg::*;
(
  input  logic [IDX_W-1:0] base,
  input  logic [DIM_W-1:0] xs,
  input  logic [DIM_W-1:0] ys,
  input  logic [DIM_W-1:0] cx,
  input  logic [DIM_W-1:0] cy,
  input  logic [DIM_W-1:0] cz,
  output logic [IDX_W-1:0] idx
);
  localparam int SZ_W = DIM_W + 1;
  localparam int PY_W = DIM_W + SZ_W;
  localparam int PL_W = 2 * SZ_W;
  localparam int PZ_W = DIM_W + PL_W;

  logic [SZ_W-1:0] xsize, ysize;
  logic [PL_W-1:0] plane;
  logic [PY_W-1:0] row_off;
  logic [PZ_W-1:0] pln_off;

  always_comb begin
    xsize   = SZ_W'(xs) + SZ_W'(1);
    ysize   = SZ_W'(ys) + SZ_W'(1);
    plane   = PL_W'(xsize) * PL_W'(ysize);
    row_off = PY_W'(cy) * PY_W'(xsize);
    pln_off = PZ_W'(cz) * PZ_W'(plane);
    idx     = base + IDX_W'(cx) + IDX_W'(row_off) + IDX_W'(pln_off);
  end
endmodule

// File: rtl/vreg_remap.sv
module vreg_remap
  import vremap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cfg_base,
  input  logic [DIM_W-1:0] cfg_xs,
  input  logic [DIM_W-1:0] cfg_ys,
  input  logic [DIM_W-1:0] cfg_zs,
  input  logic [ORD_W-1:0] cfg_order,
  input  logic             idx_ready,
  output logic             idx_valid,
  output logic [IDX_W-1:0] idx,
  output logic             idx_last
);
  vr_cfg_t          cfg_q;
  logic             active_q;
  logic             fire, adv, final_elem;
  logic [DIM_W-1:0] cx, cy, cz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (start) begin
      cfg_q <= '{base: cfg_base, xs: cfg_xs, ys: cfg_ys, zs: cfg_zs, order: cfg_order};
    end
  end

  assign fire = active_q & idx_ready;
  assign adv  = fire & ~start & ~final_elem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
    end else if (fire && final_elem) begin
      active_q <= 1'b0;
    end
  end

  vremap_walk u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .adv        (adv),
    .xs         (cfg_q.xs),
    .ys         (cfg_q.ys),
    .zs         (cfg_q.zs),
    .order      (cfg_q.order),
    .cx         (cx),
    .cy         (cy),
    .cz         (cz),
    .final_elem (final_elem)
  );

  vremap_addr u_addr (
    .base (cfg_q.base),
    .xs   (cfg_q.xs),
    .ys   (cfg_q.ys),
    .cx   (cx),
    .cy   (cy),
    .cz   (cz),
    .idx  (idx)
  );

  assign idx_valid = active_q;
  assign idx_last  = active_q & final_elem;
endmodule

// File: rtl/vreg_remap_chk.sv
module vreg_remap_chk
  import vremap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] cfg_base,
  input logic             idx_ready,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx,
  input logic             idx_last
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_valid && !start) |=> !idx_valid);

  p_first_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx_valid && idx == $past(cfg_base)));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !idx_ready && !start) |=> (idx_valid && $stable(idx) && $stable(idx_last)));

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready && idx_last && !start) |=> !idx_valid);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_last |-> idx_valid);
endmodule

bind vreg_remap vreg_remap_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cfg_base  (cfg_base),
  .idx_ready (idx_ready),
  .idx_valid (idx_valid),
  .idx       (idx),
  .idx_last  (idx_last)
);

// File: tb/vreg_remap_tb.sv
`timescale 1ns/1ps
module vreg_remap_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] cfg_base = '0;
  logic [3:0] cfg_xs = '0, cfg_ys = '0, cfg_zs = '0;
  logic [2:0] cfg_order = '0;
  logic       idx_ready = 1'b0;
  logic       idx_valid;
  logic [6:0] idx;
  logic       idx_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected configuration and progress
  int e_base, e_xs, e_ys, e_zs, e_ord, e_k;

  always #2 clk = ~clk;

  vreg_remap u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_xs(cfg_xs), .cfg_ys(cfg_ys), .cfg_zs(cfg_zs), .cfg_order(cfg_order),
    .idx_ready(idx_ready), .idx_valid(idx_valid), .idx(idx), .idx_last(idx_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int total_elems();
    return (e_xs + 1) * (e_ys + 1) * (e_zs + 1);
  endfunction

  // index of element n, from the requirement formula and order table
  function automatic int exp_idx(input int n);
    int s[3];
    int ord[3];
    int c[3];
    s[0] = e_xs + 1; s[1] = e_ys + 1; s[2] = e_zs + 1;
    case (e_ord)
      1: ord = '{0, 2, 1};
      2: ord = '{1, 0, 2};
      3: ord = '{1, 2, 0};
      4: ord = '{2, 0, 1};
      5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    c[ord[0]] = n % s[ord[0]];
    c[ord[1]] = (n / s[ord[0]]) % s[ord[1]];
    c[ord[2]] = n / (s[ord[0]] * s[ord[1]]);
    return (e_base + c[0] + c[1] * s[0] + c[2] * s[0] * s[1]) % 128;
  endfunction

  // Pulse start at a falling edge; returns at the falling edge after.
  task automatic launch(input int b, input int xs, input int ys, input int zs,
                        input int ord, input bit scramble);
    cfg_base = 7'(b); cfg_xs = 4'(xs); cfg_ys = 4'(ys); cfg_zs = 4'(zs);
    cfg_order = 3'(ord);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    e_base = b; e_xs = xs; e_ys = ys; e_zs = zs; e_ord = ord; e_k = 0;
    if (scramble) begin  // R11: changes outside start must not matter
      cfg_base = 7'(b + 37); cfg_xs = 4'(xs + 3); cfg_ys = 4'(ys + 5);
      cfg_zs = 4'(zs + 1); cfg_order = 3'(ord + 2);
    end
  endtask

  // Check and consume cnt elements; stall inserts ready-low cycles.
  task automatic consume(input int cnt, input bit stall, input string req);
    int target = e_k + cnt;
    int cyc = 0;
    while (e_k < target) begin
      idx_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      chk(idx_valid == 1'b1, req, int'(idx_valid), 1);
      chk(int'(idx) == exp_idx(e_k), req, int'(idx), exp_idx(e_k));
      chk(idx_last == (e_k == total_elems() - 1), {req, "/R7 last"},
          int'(idx_last), int'(e_k == total_elems() - 1));
      @(posedge clk);
      if (idx_ready) e_k++;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic expect_idle(input string req);
    idx_ready = 1'b1;
    chk(idx_valid == 1'b0, req, int'(idx_valid), 0);
    chk(idx_last == 1'b0, req, int'(idx_last), 0);
  endtask

  task automatic t_reset();
    expect_idle("R1 after reset");
    repeat (3) @(negedge clk);
    expect_idle("R1 idle without start");
  endtask

  task automatic t_identity();
    launch(10, 7, 1, 0, 0, 1'b1);
    chk(int'(idx) == 10, "R2 first index is base", int'(idx), 10);
    consume(16, 1'b0, "R3 identity walk / R11");
    expect_idle("R7 valid falls after final");
  endtask

  task automatic t_transpose();
    int want[12] = '{0, 4, 8, 1, 5, 9, 2, 6, 10, 3, 7, 11};
    launch(0, 3, 2, 0, 2, 1'b0);
    for (int i = 0; i < 12; i++) begin
      idx_ready = 1'b1;
      chk(int'(idx) == want[i], "R4 transposed 4x3", int'(idx), want[i]);
      @(posedge clk); @(negedge clk);
    end
    expect_idle("R4 walk ends after 12");
  endtask

  task automatic t_orders();
    for (int o = 0; o < 8; o++) begin
      launch(5 + o, 2, 1, 3, o, 1'b0);
      consume(total_elems(), o[0], "R5 order code");
      expect_idle("R5 end of 3D walk");
    end
  endtask

  task automatic t_stall();
    launch(40, 3, 3, 1, 3, 1'b0);
    consume(total_elems(), 1'b1, "R6 hold under back-pressure");
    expect_idle("R6 end");
  endtask

  task automatic t_wrap();
    launch(120, 15, 0, 0, 0, 1'b0);
    consume(16, 1'b0, "R8 modulo 128 wrap");
    expect_idle("R8 end");
  endtask

  task automatic t_restart();
    launch(0, 4, 4, 0, 0, 1'b0);
    consume(6, 1'b0, "R9 before restart");
    idx_ready = 1'b1;
    launch(64, 1, 2, 0, 1, 1'b0);
    chk(int'(idx) == 64, "R9 restart at element zero", int'(idx), 64);
    consume(total_elems(), 1'b0, "R9 new walk");
    expect_idle("R9 end");
  endtask

  task automatic t_single();
    launch(99, 0, 0, 0, 4, 1'b0);
    chk(idx_last == 1'b1, "R10 single element last", int'(idx_last), 1);
    consume(1, 1'b0, "R10 1x1x1");
    expect_idle("R10 end");
    launch(0, 15, 15, 0, 0, 1'b0);
    consume(256, 1'b0, "R10 max 16x16");
    expect_idle("R10 end max");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_transpose();
    t_orders();
    t_stall();
    t_wrap();
    t_restart();
    t_single();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule